// File: doc/BRIEF.md
# Quadrature Position Counter Axis

This block tracks the position of one encoder axis. Two quadrature phase inputs, A and B, are brought into the clock domain, decoded into up and down steps, and accumulated in a 24-bit wrapping counter. The decoder can count every edge, only the edges of A, or one edge per cycle. It also has a plain counting mode in which the two lines are treated as clock and direction, or as separate up and down clocks. Status flags record wraps, the direction of the last step, and matches against a preset value. The carry, borrow and match flags change state on each event instead of being set once.

A host reaches the axis one byte at a time over two valid/ready channels. The write channel carries either a data byte or a command byte. A data byte fills the next byte of the preset. A command byte selects one of four sub-registers through its top two bits. The read channel returns either the status byte or the next byte of the output latch. Preset and latch share one byte pointer, which starts at the least significant byte and moves on after each data access. Both channels hold ready high, so the block never applies back-pressure: a write is taken on every cycle in which `wr_valid` is high, and every read request gets its response exactly one cycle later. An external strobe, or a command, copies the live count into the output latch, so that a control loop can read a value sampled at a fixed instant.

Top module: `quad_axis_counter`

## Requirements
- R1: After reset the status byte reads 0x18, the output latch holds 0, the preset holds 0xFFFFFF, quadrature decoding and the encoder inputs are off, the count is 0, and both ready outputs are high. Status byte: bits 7:5 read 0, bit 4 is UP, bit 3 is SIGN, bit 2 is CMP, bit 1 is CRY, bit 0 is BRW.
- R2: A data write loads the preset byte chosen by the pointer. A latch read returns the latch byte chosen by the pointer. The order is least significant byte first, the pointer wraps to byte 0 after byte 2, and `rsp_valid` with `rsp_data` follows a read request by exactly one cycle.
- R3: Command bits 7:6 pick the sub-register: 00 master, 01 input, 10 output, 11 quadrature. An output command changes nothing. A quadrature command sets the mode from bits 1:0: 00 off, 01 x1, 10 x2, 11 x4.
- R4: Each master bit requests one action, and any combination of bits may be set together. Bit 5 resets everything except the count, UP and latch: flags cleared, SIGN set, pointer 0, preset 0xFFFFFF. Bit 4 clears CMP. Bit 3 loads the preset into the count. Bit 2 clears the count, CRY and BRW and sets SIGN. Bit 1 copies the count into the latch. Bit 0 sets the pointer to 0.
- R5: In x4 mode every legal transition counts. With the state written {A,B}, the sequence 00→10→11→01→00 counts up and the reverse sequence counts down.
- R6: In x2 mode only transitions of A count, with the direction taken from the x4 rule. In x1 mode only 00→10 counts up and only 10→00 counts down.
- R7: With quadrature off and input bit 3 set, a rising edge of A steps down if B is 1 and up otherwise. With input bit 3 clear, a rising edge of A steps up and a rising edge of B steps down. When both rise in the same cycle, nothing counts.
- R8: Input bit 0 enables encoder counting; while it is 0, encoder activity leaves the count unchanged. Input bit 1 steps up once and bit 2 steps down once, whether or not the encoder is enabled.
- R9: Stepping up from 0xFFFFFF gives 0, toggles CRY and sets SIGN. Stepping down from 0 gives 0xFFFFFF, toggles BRW and clears SIGN.
- R10: CMP toggles whenever a count step produces a value equal to the preset.
- R11: A rising edge on `latch_strobe` is synchronised and copies the count into the output latch. Without such an edge or a copy command, the latch keeps its value.
- R12: A transition in which A and B both change is ignored. With one phase held still, edges on the other phase make the count alternate up and down.
- R13: A clear or load command that coincides with a count step wins, and the step is lost.
- R14: UP is 1 after a step up and 0 after a step down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder phase A (asynchronous) |
| enc_b | input | 1 | Encoder phase B (asynchronous) |
| latch_strobe | input | 1 | External latch request, rising edge acts (asynchronous) |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Always high; no back-pressure |
| wr_cmd | input | 1 | 1 = command byte, 0 = preset data byte |
| wr_data | input | 8 | Write byte |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Always high; no back-pressure |
| rd_status | input | 1 | 1 = status byte, 0 = next latch byte |
| rsp_valid | output | 1 | Read response valid, one cycle after the request |
| rsp_data | output | 8 | Read response byte |

## Verification
A count step and a host command that rewrites the counter can land on the same clock edge. The bench provokes this by changing phase A and then issuing a clear command exactly two cycles later, which is when the decoded step reaches the counter through the two-flop synchroniser. It judges the result by reading the latched count: a value of zero shows that the clear won and the step was dropped, and a further step shows that counting carries on normally. The same register path is checked when a software step wraps the counter and moves the flags in a single cycle.

// File: rtl/qac_pkg.sv
package qac_pkg;
  typedef enum logic [1:0] {
    QM_OFF = 2'b00,
    QM_X1  = 2'b01,
    QM_X2  = 2'b10,
    QM_X4  = 2'b11
  } qmode_e;

  typedef enum logic [1:0] {
    SUB_MASTER = 2'b00,
    SUB_INPUT  = 2'b01,
    SUB_OUTPUT = 2'b10,
    SUB_QUAD   = 2'b11
  } subreg_e;

  typedef struct packed {
    logic up;
    logic sign;
    logic cmp;
    logic cry;
    logic brw;
  } flags_t;
endpackage

// File: rtl/qac_decoder.sv
module qac_decoder
  import qac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enc_a,
  input  logic   enc_b,
  input  qmode_e qmode,
  input  logic   dir_mode,
  input  logic   enable,
  output logic   enc_up,
  output logic   enc_dn
);
  logic [SYNC_STAGES-1:0] a_sh, b_sh;
  logic [1:0] cur, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sh   <= '0;
      b_sh   <= '0;
      prev_q <= 2'b00;
    end else begin
      a_sh   <= {a_sh[SYNC_STAGES-2:0], enc_a};
      b_sh   <= {b_sh[SYNC_STAGES-2:0], enc_b};
      prev_q <= cur;
    end
  end

  assign cur = {a_sh[SYNC_STAGES-1], b_sh[SYNC_STAGES-1]};

  logic fwd, bwd, a_chg, a_rise, b_rise;
  always_comb begin
    fwd = (prev_q == 2'b00 && cur == 2'b10) || (prev_q == 2'b10 && cur == 2'b11) ||
          (prev_q == 2'b11 && cur == 2'b01) || (prev_q == 2'b01 && cur == 2'b00);
    bwd = (prev_q == 2'b00 && cur == 2'b01) || (prev_q == 2'b01 && cur == 2'b11) ||
          (prev_q == 2'b11 && cur == 2'b10) || (prev_q == 2'b10 && cur == 2'b00);
    a_chg  = prev_q[1] ^ cur[1];
    a_rise = ~prev_q[1] & cur[1];
    b_rise = ~prev_q[0] & cur[0];
  end

  logic up_raw, dn_raw;
  always_comb begin
    up_raw = 1'b0;
    dn_raw = 1'b0;
    unique case (qmode)
      QM_X4: begin
        up_raw = fwd;
        dn_raw = bwd;
      end
      QM_X2: begin
        up_raw = fwd & a_chg;
        dn_raw = bwd & a_chg;
      end
      QM_X1: begin
        up_raw = (prev_q == 2'b00) && (cur == 2'b10);
        dn_raw = (prev_q == 2'b10) && (cur == 2'b00);
      end
      default: begin
        if (dir_mode) begin
          up_raw = a_rise & ~cur[0];
          dn_raw = a_rise & cur[0];
        end else begin
          up_raw = a_rise & ~b_rise;
          dn_raw = b_rise & ~a_rise;
        end
      end
    endcase
  end

  assign enc_up = enable & up_raw;
  assign enc_dn = enable & dn_raw;
endmodule

// File: rtl/qac_counter.sv
module qac_counter
  import qac_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic [CNT_W-1:0] preset,
  input  logic             clr_cnt,
  input  logic             load_cnt,
  input  logic             clr_cmp,
  input  logic             rst_all,
  output logic [CNT_W-1:0] cnt,
  output flags_t           flg
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] cnt_q, inc_v, dec_v;
  flags_t flg_q;

  assign inc_v = cnt_q + 1'b1;
  assign dec_v = cnt_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flg_q <= '{up: 1'b1, sign: 1'b1, cmp: 1'b0, cry: 1'b0, brw: 1'b0};
    end else begin
      if (clr_cnt) begin
        cnt_q      <= '0;
        flg_q.cry  <= 1'b0;
        flg_q.brw  <= 1'b0;
        flg_q.sign <= 1'b1;
      end else if (load_cnt) begin
        cnt_q <= preset;
      end else if (step_up) begin
        cnt_q    <= inc_v;
        flg_q.up <= 1'b1;
        if (cnt_q == MAXV) begin
          flg_q.cry  <= ~flg_q.cry;
          flg_q.sign <= 1'b1;
        end
        if (inc_v == preset) flg_q.cmp <= ~flg_q.cmp;
      end else if (step_dn) begin
        cnt_q    <= dec_v;
        flg_q.up <= 1'b0;
        if (cnt_q == '0) begin
          flg_q.brw  <= ~flg_q.brw;
          flg_q.sign <= 1'b0;
        end
        if (dec_v == preset) flg_q.cmp <= ~flg_q.cmp;
      end
      if (rst_all) begin
        flg_q.cmp  <= 1'b0;
        flg_q.cry  <= 1'b0;
        flg_q.brw  <= 1'b0;
        flg_q.sign <= 1'b1;
      end
      if (clr_cmp) flg_q.cmp <= 1'b0;
    end
  end

  assign cnt = cnt_q;
  assign flg = flg_q;
endmodule

// File: rtl/qac_host.sv
module qac_host
  import qac_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NBYTES     = CNT_W / BYTE_W,
  localparam int PTR_W      = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_valid,
  input  logic              rd_status,
  input  logic              latch_strobe,
  input  logic [CNT_W-1:0]  cnt,
  input  flags_t            flg,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic [CNT_W-1:0]  preset,
  output qmode_e            qmode,
  output logic              in_en,
  output logic              dir_mode,
  output logic              sw_inc,
  output logic              sw_dec,
  output logic              clr_cnt,
  output logic              load_cnt,
  output logic              clr_cmp,
  output logic              rst_all,
  output logic [PTR_W-1:0]  ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

  logic    cmd_wr, data_wr, data_rd;
  subreg_e sub;
  logic    m_latch, m_ptr0;

  assign cmd_wr  = wr_valid & wr_cmd;
  assign data_wr = wr_valid & ~wr_cmd;
  assign data_rd = rd_valid & ~rd_status;
  assign sub     = subreg_e'(wr_data[7:6]);

  always_comb begin
    logic m;
    m        = cmd_wr && (sub == SUB_MASTER);
    rst_all  = m & wr_data[5];
    clr_cmp  = m & wr_data[4];
    load_cnt = m & wr_data[3];
    clr_cnt  = m & wr_data[2];
    m_latch  = m & wr_data[1];
    m_ptr0   = m & wr_data[0];
    sw_inc   = cmd_wr && (sub == SUB_INPUT) && wr_data[1];
    sw_dec   = cmd_wr && (sub == SUB_INPUT) && wr_data[2];
  end

  logic [SYNC_STAGES-1:0] stb_sh;
  logic stb_prev, stb_rise;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_sh   <= '0;
      stb_prev <= 1'b0;
    end else begin
      stb_sh   <= {stb_sh[SYNC_STAGES-2:0], latch_strobe};
      stb_prev <= stb_sh[SYNC_STAGES-1];
    end
  end
  assign stb_rise = stb_sh[SYNC_STAGES-1] & ~stb_prev;

  logic [CNT_W-1:0] latch_q, preset_q;
  logic [PTR_W-1:0] ptr_q;
  logic [BYTE_W-1:0] latch_byte;

  always_comb begin
    latch_byte = '0;
    for (int i = 0; i < NBYTES; i++)
      if (ptr_q == PTR_W'(i)) latch_byte = latch_q[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q   <= '0;
      preset_q  <= '1;
      ptr_q     <= '0;
      qmode     <= QM_OFF;
      in_en     <= 1'b0;
      dir_mode  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      if (rd_valid)
        rsp_data <= rd_status ? {{(BYTE_W-5){1'b0}}, flg.up, flg.sign, flg.cmp, flg.cry, flg.brw}
                              : latch_byte;
      if (data_wr)
        for (int i = 0; i < NBYTES; i++)
          if (ptr_q == PTR_W'(i)) preset_q[i*BYTE_W +: BYTE_W] <= wr_data;
      if (data_wr || data_rd)
        ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (stb_rise || m_latch) latch_q <= cnt;
      if (cmd_wr && sub == SUB_INPUT) begin
        in_en    <= wr_data[0];
        dir_mode <= wr_data[3];
      end
      if (cmd_wr && sub == SUB_QUAD) qmode <= qmode_e'(wr_data[1:0]);
      if (m_ptr0 || rst_all) ptr_q <= '0;
      if (rst_all) preset_q <= '1;
    end
  end

  assign preset = preset_q;
  assign ptr    = ptr_q;
endmodule

// File: rtl/quad_axis_counter.sv
module quad_axis_counter
  import qac_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NBYTES     = CNT_W / BYTE_W,
  localparam int PTR_W      = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              latch_strobe,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_cmd,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic              rd_status,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  qmode_e           qmode_w;
  logic             in_en_w, dir_mode_w, sw_inc_w, sw_dec_w;
  logic             clr_cnt_w, load_cnt_w, clr_cmp_w, rst_all_w;
  logic             enc_up_w, enc_dn_w, step_up_w, step_dn_w;
  logic [CNT_W-1:0] preset_w, cnt_w;
  logic [PTR_W-1:0] ptr_w;
  flags_t           flg_w;

  assign wr_ready = 1'b1;
  assign rd_ready = 1'b1;

  qac_decoder #(.SYNC_STAGES(SYNC_STAGES)) dec_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .qmode(qmode_w), .dir_mode(dir_mode_w), .enable(in_en_w),
    .enc_up(enc_up_w), .enc_dn(enc_dn_w)
  );

  always_comb begin
    if (sw_inc_w | sw_dec_w) begin
      step_up_w = sw_inc_w & ~sw_dec_w;
      step_dn_w = sw_dec_w & ~sw_inc_w;
    end else begin
      step_up_w = enc_up_w;
      step_dn_w = enc_dn_w;
    end
  end

  qac_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .step_up(step_up_w), .step_dn(step_dn_w),
    .preset(preset_w), .clr_cnt(clr_cnt_w), .load_cnt(load_cnt_w),
    .clr_cmp(clr_cmp_w), .rst_all(rst_all_w), .cnt(cnt_w), .flg(flg_w)
  );

  qac_host #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .SYNC_STAGES(SYNC_STAGES)) host_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_status(rd_status), .latch_strobe(latch_strobe),
    .cnt(cnt_w), .flg(flg_w), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .preset(preset_w), .qmode(qmode_w), .in_en(in_en_w), .dir_mode(dir_mode_w),
    .sw_inc(sw_inc_w), .sw_dec(sw_dec_w), .clr_cnt(clr_cnt_w), .load_cnt(load_cnt_w),
    .clr_cmp(clr_cmp_w), .rst_all(rst_all_w), .ptr(ptr_w)
  );
endmodule

// File: rtl/qac_checker.sv
module qac_checker
  import qac_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NBYTES = 3,
  parameter int PTR_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic             rsp_valid,
  input logic [PTR_W-1:0] ptr,
  input logic [CNT_W-1:0] cnt,
  input flags_t           flg,
  input logic             step_up,
  input logic             step_dn,
  input logic             clr_cnt,
  input logic             load_cnt,
  input logic             rst_all
);
  localparam logic [CNT_W-1:0] ONES = '1;
  logic [CNT_W-1:0] prev_cnt, diff;
  always_ff @(posedge clk) prev_cnt <= cnt;
  assign diff = cnt - prev_cnt;

  a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < NBYTES);
  a_r2_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_cnt || load_cnt) |=> (diff == '0 || diff == CNT_W'(1) || diff == ONES));
  a_r13_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cnt |=> cnt == '0);
  a_r9_cry_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && cnt != ONES && !clr_cnt && !load_cnt && !rst_all) |=> $stable(flg.cry));
  a_r9_sign_after_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && cnt == ONES && !clr_cnt && !load_cnt) |=> (flg.sign && cnt == '0));
  a_r9_sign_after_unf: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && cnt == '0 && !clr_cnt && !load_cnt && !rst_all) |=> (!flg.sign && cnt == ONES));
  a_r14_up_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !clr_cnt && !load_cnt) |=> flg.up);
  a_r14_down_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !clr_cnt && !load_cnt) |=> !flg.up);
endmodule

bind quad_axis_counter qac_checker #(.CNT_W(CNT_W), .NBYTES(NBYTES), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rsp_valid(rsp_valid), .ptr(ptr_w),
  .cnt(cnt_w), .flg(flg_w), .step_up(step_up_w), .step_dn(step_dn_w),
  .clr_cnt(clr_cnt_w), .load_cnt(load_cnt_w), .rst_all(rst_all_w)
);

// File: tb/quad_axis_counter_tb_top.sv
`timescale 1ns/1ps
module quad_axis_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, latch_strobe = 1'b0;
  logic wr_valid = 1'b0, wr_cmd = 1'b0, rd_valid = 1'b0, rd_status = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wr_ready, rd_ready, rsp_valid;
  logic [7:0] rsp_data;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  quad_axis_counter dut_i (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .latch_strobe(latch_strobe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_status(rd_status),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input bit is_cmd, input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_cmd = is_cmd; wr_data = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd_byte(input bit st, output logic [7:0] v);
    @(negedge clk);
    rd_valid = 1'b1; rd_status = st;
    @(negedge clk);
    rd_valid = 1'b0;
    if (!rsp_valid) check("R2 rsp_valid", 0, 1);
    v = rsp_data;
  endtask

  task automatic rd_latch(output logic [23:0] v);
    logic [7:0] b0, b1, b2;
    rd_byte(1'b0, b0); rd_byte(1'b0, b1); rd_byte(1'b0, b2);
    v = {b2, b1, b0};
  endtask

  task automatic read_count(output logic [23:0] v);
    wr_byte(1'b1, 8'h03);
    rd_latch(v);
  endtask

  task automatic enc_go(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic fwd_cycle();
    enc_go(1, 0); enc_go(1, 1); enc_go(0, 1); enc_go(0, 0);
  endtask

  task automatic t_reset();
    logic [7:0] s; logic [23:0] v;
    check("R1 wr_ready", wr_ready, 1);
    check("R1 rd_ready", rd_ready, 1);
    rd_byte(1'b1, s);
    check("R1 status", s, 8'h18);
    rd_latch(v);
    check("R1 latch", v, 0);
    wr_byte(1'b1, 8'h08);
    read_count(v);
    check("R1 preset ones", v, 24'hFFFFFF);
  endtask

  task automatic t_preset();
    logic [23:0] v; logic [7:0] b;
    wr_byte(1'b1, 8'h01);
    wr_byte(1'b0, 8'h56); wr_byte(1'b0, 8'h34); wr_byte(1'b0, 8'h12);
    wr_byte(1'b1, 8'h08);
    read_count(v);
    check("R2 R4 preset load", v, 24'h123456);
    rd_byte(1'b0, b);
    check("R2 pointer wrap", b, 8'h56);
  endtask

  task automatic t_quad_x4();
    logic [23:0] v; logic [7:0] s;
    wr_byte(1'b1, 8'h04); wr_byte(1'b1, 8'hC3); wr_byte(1'b1, 8'h41);
    fwd_cycle(); fwd_cycle();
    read_count(v);
    check("R5 x4 up", v, 8);
    rd_byte(1'b1, s);
    check("R14 up flag", s[4], 1);
    enc_go(0, 1); enc_go(1, 1); enc_go(1, 0);
    read_count(v);
    check("R5 x4 down", v, 5);
    rd_byte(1'b1, s);
    check("R14 down flag", s[4], 0);
    enc_go(0, 0);
  endtask

  task automatic t_x2_x1();
    logic [23:0] v;
    wr_byte(1'b1, 8'h04); wr_byte(1'b1, 8'hC2);
    fwd_cycle(); fwd_cycle();
    read_count(v);
    check("R6 x2", v, 4);
    wr_byte(1'b1, 8'h04); wr_byte(1'b1, 8'hC1);
    fwd_cycle(); fwd_cycle();
    read_count(v);
    check("R6 x1", v, 2);
  endtask

  task automatic t_disconnected();
    logic [23:0] v;
    wr_byte(1'b1, 8'h04); wr_byte(1'b1, 8'hC3);
    enc_go(1, 0);
    read_count(v);
    check("R12 alternate up", v, 1);
    enc_go(0, 0);
    read_count(v);
    check("R12 alternate down", v, 0);
    enc_go(1, 1); enc_go(0, 0);
    read_count(v);
    check("R12 illegal ignored", v, 0);
    wr_byte(1'b1, 8'h40);
    fwd_cycle();
    read_count(v);
    check("R8 disabled ignored", v, 0);
  endtask

  task automatic t_nonquad();
    logic [23:0] v; logic [7:0] s;
    wr_byte(1'b1, 8'h04); wr_byte(1'b1, 8'hC0); wr_byte(1'b1, 8'h49);
    repeat (3) begin enc_go(1, 0); enc_go(0, 0); end
    enc_go(0, 1);
    repeat (2) begin enc_go(1, 1); enc_go(0, 1); end
    enc_go(0, 0);
    read_count(v);
    check("R7 clock/direction", v, 1);
    wr_byte(1'b1, 8'h04); wr_byte(1'b1, 8'h41);
    repeat (2) begin enc_go(1, 0); enc_go(0, 0); end
    repeat (3) begin enc_go(0, 1); enc_go(0, 0); end
    read_count(v);
    check("R7 R9 up/down clocks wrap", v, 24'hFFFFFF);
    rd_byte(1'b1, s);
    check("R9 borrow status", s, 8'h01);
  endtask

  task automatic t_software_wrap();
    logic [23:0] v; logic [7:0] s;
    wr_byte(1'b1, 8'h01);
    wr_byte(1'b0, 8'hFE); wr_byte(1'b0, 8'hFF); wr_byte(1'b0, 8'hFF);
    wr_byte(1'b1, 8'h04); wr_byte(1'b1, 8'h08);
    wr_byte(1'b1, 8'h42);
    rd_byte(1'b1, s);
    check("R8 software inc", s, 8'h18);
    wr_byte(1'b1, 8'h42);
    read_count(v);
    check("R9 overflow value", v, 0);
    rd_byte(1'b1, s);
    check("R9 carry status", s, 8'h1A);
    wr_byte(1'b1, 8'h44);
    rd_byte(1'b1, s);
    check("R9 underflow status", s, 8'h03);
    wr_byte(1'b1, 8'h44);
    read_count(v);
    check("R8 software dec", v, 24'hFFFFFE);
    rd_byte(1'b1, s);
    check("R10 compare toggle", s, 8'h07);
    wr_byte(1'b1, 8'h10);
    rd_byte(1'b1, s);
    check("R4 clear compare", s, 8'h03);
  endtask

  task automatic t_strobe();
    logic [23:0] v;
    wr_byte(1'b1, 8'h42);
    wr_byte(1'b1, 8'h01);
    rd_latch(v);
    check("R11 latch held", v, 24'hFFFFFE);
    @(negedge clk) latch_strobe = 1'b1;
    repeat (5) @(negedge clk);
    latch_strobe = 1'b0;
    wr_byte(1'b1, 8'h01);
    rd_latch(v);
    check("R11 strobe copy", v, 24'hFFFFFF);
  endtask

  task automatic t_reset_all();
    logic [23:0] v; logic [7:0] s;
    wr_byte(1'b1, 8'h04);
    wr_byte(1'b1, 8'h20);
    rd_byte(1'b1, s);
    check("R4 reset-all status", s, 8'h18);
    wr_byte(1'b1, 8'h08);
    read_count(v);
    check("R4 reset-all preset", v, 24'hFFFFFF);
  endtask

  task automatic t_collision();
    logic [23:0] v; logic [7:0] s;
    wr_byte(1'b1, 8'hC3); wr_byte(1'b1, 8'h41); wr_byte(1'b1, 8'h04);
    enc_go(1, 0);
    read_count(v);
    check("R5 step before collision", v, 1);
    @(negedge clk);
    enc_a = 1'b1; enc_b = 1'b1;
    @(negedge clk);
    wr_byte(1'b1, 8'h04);
    repeat (3) @(negedge clk);
    read_count(v);
    check("R13 clear beats step", v, 0);
    enc_go(0, 1);
    read_count(v);
    check("R13 counting resumes", v, 1);
    rd_byte(1'b1, s);
    wr_byte(1'b1, 8'hBF);
    read_count(v);
    check("R3 output cmd count", v, 1);
    begin
      logic [7:0] s2;
      rd_byte(1'b1, s2);
      check("R3 output cmd status", s2, s);
    end
    enc_go(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_preset();
    t_quad_x4();
    t_x2_x1();
    t_disconnected();
    t_nonquad();
    t_software_wrap();
    t_strobe();
    t_reset_all();
    t_collision();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule